// File: doc/BRIEF.md
# Incremental Fixed-Point PID Regulator

This block is a discrete-time PID regulator in velocity form. Each time the sample strobe is high on a clock edge, it takes one measurement and one setpoint. It forms the control error and moves its output by a weighted step. The step is built from the error, the current measurement and the two measurements that came before it. The previous output is the base the step is added to, so integral action comes from accumulation in the output register itself. The proportional and derivative actions act on the measurement, not on the error, so a step in the setpoint does not cause a derivative kick.

Four signed coefficient inputs weight the four terms. They are fixed-point numbers with `FRAC_W` fraction bits and are computed off-chip from the desired gains:
- the error weight is the integral gain times the sample period;
- the current-measurement weight is minus the proportional gain, minus the derivative gain over the period;
- the first-history weight is the proportional gain plus twice the derivative gain over the period;
- the second-history weight is minus the derivative gain over the period.

The measurement, output and coefficient widths are parameters, each 16 bits by default. The output is clamped to its signed range, and this clamp is the only anti-windup.

Top module: `incr_pid`

## Requirements
- R1: The error is formed as `target_in - meas_in` in signed arithmetic one bit wider than the measurement, so the full difference of two extreme inputs is kept exactly.
- R2: On a strobe, the new output is the saturated value of `u_prev + ((c_err*e + c_y0*y(k) + c_y1*y(k-1) + c_y2*y(k-2)) >>> FRAC_W)`. The shift is arithmetic, so it rounds toward minus infinity: a weighted sum of -1 gives a step of -1, and a sum of +1 gives a step of 0.
- R3: On a strobe, the older history slot takes the value of the newer slot, and the newer slot takes the current measurement. Without a strobe, both slots keep their values.
- R4: `ctl_out` changes only at the clock edge that samples `smp_strb` high. `out_vld` is high for exactly the cycle after each such edge and low at all other times.
- R5: While `smp_strb` is low, `ctl_out` holds its value.
- R6: A result above the largest positive output value is clamped to `2**(OUT_W-1)-1`.
- R7: A result below the most negative output value is clamped to `-2**(OUT_W-1)`.
- R8: Reset (`rst_n` low) clears the output, both history slots and `out_vld` to zero.
- R9: The weighted sum is carried in an accumulator wide enough to hold four extreme products without wrapping. Large products of opposite sign therefore cancel exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_strb | input | 1 | Sample strobe: take inputs and update the output |
| meas_in | input | IN_W | Measured value y(k), signed |
| target_in | input | IN_W | Setpoint, signed |
| c_err | input | COEF_W | Error weight, signed fixed point |
| c_y0 | input | COEF_W | Current-measurement weight, signed fixed point |
| c_y1 | input | COEF_W | Weight for y(k-1), signed fixed point |
| c_y2 | input | COEF_W | Weight for y(k-2), signed fixed point |
| ctl_out | output | OUT_W | Regulator output u(k), signed |
| out_vld | output | 1 | One-cycle pulse after each update |

## Verification
The assertions check the timing relations on every cycle:
- a strobe is followed by a valid pulse, and no other cycle has one;
- the output stays still between strobes;
- the history slots take the sample and its predecessor on each strobe and stay unchanged otherwise.

The arithmetic can only be shown by the bench's scenarios, which compare each update against an independent model. These scenarios cover:
- floor rounding of negative sums;
- clamping at both ends of the range;
- exact cancellation of near-extreme products;
- each history slot's contribution, isolated through its own coefficient;
- the clearing of history by a mid-run reset.

// File: rtl/incr_pid_pkg.sv
package incr_pid_pkg;
   // Accumulator width: product of coefficient and (IN_W+1)-bit error,
   // plus two bits of growth for summing four terms.
   function automatic int acc_width(input int in_w, input int coef_w);
      return in_w + coef_w + 3;
   endfunction

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/incr_pid_hist.sv
module incr_pid_hist #(
   parameter int IN_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   shift,
   input  logic signed [IN_W-1:0] y_now,
   output logic signed [IN_W-1:0] y_d1,
   output logic signed [IN_W-1:0] y_d2
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_d1 <= '0;
         y_d2 <= '0;
      end else if (shift) begin
         y_d2 <= y_d1;
         y_d1 <= y_now;
      end
   end

   // R3: newer slot captures the sample taken on the strobe
   a_r3_newer_slot : assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (y_d1 == $past(y_now)));
   // R3: older slot takes the previous newer value
   a_r3_older_slot : assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (y_d2 == $past(y_d1)));
   // R3: slots hold without a strobe
   a_r3_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !shift |=> ($stable(y_d1) && $stable(y_d2)));
endmodule

// File: rtl/incr_pid_mac.sv
module incr_pid_mac
   import incr_pid_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 8,
   localparam int ACC_W = acc_width(IN_W, COEF_W)
) (
   input  logic signed [IN_W-1:0]   y_now,
   input  logic signed [IN_W-1:0]   y_d1,
   input  logic signed [IN_W-1:0]   y_d2,
   input  logic signed [IN_W-1:0]   target,
   input  logic signed [COEF_W-1:0] k_err,
   input  logic signed [COEF_W-1:0] k_y0,
   input  logic signed [COEF_W-1:0] k_y1,
   input  logic signed [COEF_W-1:0] k_y2,
   output logic signed [ACC_W-1:0]  step
);
   localparam int E_W = IN_W + 1;

   logic signed [E_W-1:0]   err;
   logic signed [ACC_W-1:0] p_err, p_y0, p_y1, p_y2, acc;

   // R1: error with one extra bit so extremes never wrap
   assign err   = E_W'(target) - E_W'(y_now);
   assign p_err = ACC_W'(k_err) * ACC_W'(err);
   assign p_y0  = ACC_W'(k_y0) * ACC_W'(y_now);
   assign p_y1  = ACC_W'(k_y1) * ACC_W'(y_d1);
   assign p_y2  = ACC_W'(k_y2) * ACC_W'(y_d2);
   // R9: ACC_W bits hold the sum of four worst-case products
   assign acc   = p_err + p_y0 + p_y1 + p_y2;

   generate
      if (FRAC_W == 0) begin : g_int
         assign step = acc;
      end else begin : g_frac
         // R2: arithmetic shift, rounds toward minus infinity
         assign step = acc >>> FRAC_W;
      end
   endgenerate
endmodule

// File: rtl/incr_pid_sat.sv
module incr_pid_sat
   import incr_pid_pkg::*;
#(
   parameter int ACC_W = 35,
   parameter int OUT_W = 16
) (
   input  logic signed [OUT_W-1:0] u_prev,
   input  logic signed [ACC_W-1:0] step,
   output logic signed [OUT_W-1:0] u_next
);
   localparam int SUM_W = max_of(ACC_W, OUT_W) + 1;
   localparam logic signed [SUM_W-1:0] MAXV =
      {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [SUM_W-1:0] MINV = ~MAXV;

   logic signed [SUM_W-1:0] total;

   assign total = SUM_W'(u_prev) + SUM_W'(step);

   always_comb begin
      if (total > MAXV)       u_next = MAXV[OUT_W-1:0];   // R6
      else if (total < MINV)  u_next = MINV[OUT_W-1:0];   // R7
      else                    u_next = total[OUT_W-1:0];
   end
endmodule

// File: rtl/incr_pid.sv
module incr_pid
   import incr_pid_pkg::*;
#(
   parameter int IN_W   = 16,
   parameter int OUT_W  = 16,
   parameter int COEF_W = 16,
   parameter int FRAC_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     smp_strb,
   input  logic signed [IN_W-1:0]   meas_in,
   input  logic signed [IN_W-1:0]   target_in,
   input  logic signed [COEF_W-1:0] c_err,
   input  logic signed [COEF_W-1:0] c_y0,
   input  logic signed [COEF_W-1:0] c_y1,
   input  logic signed [COEF_W-1:0] c_y2,
   output logic signed [OUT_W-1:0]  ctl_out,
   output logic                     out_vld
);
   localparam int ACC_W = acc_width(IN_W, COEF_W);

   generate
      if (IN_W < 2 || OUT_W < 2 || COEF_W < 2)
         $error("incr_pid: widths must be at least 2");
      if (FRAC_W < 0 || FRAC_W >= ACC_W)
         $error("incr_pid: FRAC_W out of range");
   endgenerate

   logic signed [IN_W-1:0]  y_d1, y_d2;
   logic signed [ACC_W-1:0] step;
   logic signed [OUT_W-1:0] u_next;

   incr_pid_hist #(.IN_W(IN_W)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .shift (smp_strb),
      .y_now (meas_in),
      .y_d1  (y_d1),
      .y_d2  (y_d2)
   );

   incr_pid_mac #(.IN_W(IN_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mac (
      .y_now  (meas_in),
      .y_d1   (y_d1),
      .y_d2   (y_d2),
      .target (target_in),
      .k_err  (c_err),
      .k_y0   (c_y0),
      .k_y1   (c_y1),
      .k_y2   (c_y2),
      .step   (step)
   );

   incr_pid_sat #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_sat (
      .u_prev (ctl_out),
      .step   (step),
      .u_next (u_next)
   );

   // R8: synchronous clear; R4/R5: update only on strobe
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_out <= '0;
         out_vld <= 1'b0;
      end else begin
         out_vld <= smp_strb;
         if (smp_strb) ctl_out <= u_next;
      end
   end

   a_r4_vld_after_strb : assert property (@(posedge clk) disable iff (!rst_n)
      smp_strb |=> out_vld);
   a_r4_no_stray_vld : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_strb |=> !out_vld);
   a_r5_hold_output : assert property (@(posedge clk) disable iff (!rst_n)
      !smp_strb |=> $stable(ctl_out));
endmodule

// File: tb/incr_pid_tb.sv
module incr_pid_tb;
   localparam int IN_W = 16, OUT_W = 16, COEF_W = 16, FRAC_W = 8;
   localparam longint OMAX = (64'sd1 <<< (OUT_W-1)) - 1;
   localparam longint OMIN = -(64'sd1 <<< (OUT_W-1));
   localparam int ONE = 1 << FRAC_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_strb = 1'b0;
   logic signed [IN_W-1:0]   meas_in = '0, target_in = '0;
   logic signed [COEF_W-1:0] c_err = '0, c_y0 = '0, c_y1 = '0, c_y2 = '0;
   logic signed [OUT_W-1:0]  ctl_out;
   logic out_vld;

   int n_tests = 0, n_fail = 0;
   longint m_u = 0, m_y1 = 0, m_y2 = 0;
   longint exp_q[$];
   string  tag_q[$];

   always #10 clk = ~clk;

   incr_pid #(.IN_W(IN_W), .OUT_W(OUT_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .smp_strb(smp_strb), .meas_in(meas_in),
      .target_in(target_in), .c_err(c_err), .c_y0(c_y0), .c_y1(c_y1),
      .c_y2(c_y2), .ctl_out(ctl_out), .out_vld(out_vld)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // Monitor: pops an expected item for each valid pulse
   always @(negedge clk) begin
      if (rst_n && out_vld) begin
         if (exp_q.size() == 0) check("R4 stray valid", 1, 0);
         else check(tag_q.pop_front(), longint'(ctl_out), exp_q.pop_front());
      end
   end

   // Driver: one sample, expected value from the model
   task automatic sample(input string req, input longint t, input longint y,
                         input longint k0, input longint k1,
                         input longint k2, input longint k3);
      longint acc, nu;
      @(negedge clk);
      target_in = IN_W'(t); meas_in = IN_W'(y);
      c_err = COEF_W'(k0); c_y0 = COEF_W'(k1); c_y1 = COEF_W'(k2); c_y2 = COEF_W'(k3);
      smp_strb = 1'b1;
      acc = k0*(t-y) + k1*y + k2*m_y1 + k3*m_y2;
      nu  = m_u + (acc >>> FRAC_W);
      if (nu > OMAX) nu = OMAX;
      if (nu < OMIN) nu = OMIN;
      m_u = nu; m_y2 = m_y1; m_y1 = y;
      exp_q.push_back(nu); tag_q.push_back(req);
      @(negedge clk);
      smp_strb = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      m_u = 0; m_y1 = 0; m_y2 = 0;
      check("R8 reset output", longint'(ctl_out), 0);
      check("R8 reset valid", longint'(out_vld), 0);
      rst_n = 1'b1;
   endtask

   initial begin
      #4_000_000;
      check("watchdog", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      longint held;
      do_reset();
      // R1: integral-only accumulation of the error
      for (int i = 0; i < 3; i++) sample("R1 error term", 100, 40, ONE, 0, 0, 0);
      sample("R1 wide error", 32767, -32768, 1, 0, 0, 0);
      // R5: hold without strobe, and no valid pulse (R4)
      held = longint'(ctl_out);
      repeat (5) @(negedge clk);
      check("R5 hold", longint'(ctl_out), held);
      check("R4 no valid", longint'(out_vld), 0);
      // R2: floor rounding of the shifted sum
      sample("R2 floor neg", 1, 0, -1, 0, 0, 0);
      sample("R2 floor pos", 1, 0, 1, 0, 0, 0);
      // R3: isolate each history slot through its weight
      sample("R3 load", 0, 300, 0, 0, 0, 0);
      sample("R3 load", 0, -70, 0, 0, 0, 0);
      sample("R3 newer slot", 0, 5, 0, 0, ONE, 0);
      sample("R3 older slot", 0, 9, 0, 0, 0, ONE);
      // R2: mixed coefficients over a pattern
      for (int i = 0; i < 16; i++)
         sample("R2 mixed", (i*37)%200 - 100, (i*53)%180 - 90,
                (i*13)%90 - 40, -((i*7)%60), (i*11)%80, -((i*5)%30));
      // R6 / R7: clamping
      for (int i = 0; i < 3; i++) sample("R6 clamp high", 32767, -32768, 32767, 0, 0, 0);
      for (int i = 0; i < 3; i++) sample("R7 clamp low", -32768, 32767, 32767, 0, 0, 0);
      // R9: near-extreme products cancel exactly
      do_reset();
      sample("R9 load", 0, -32768, 0, 0, 0, 0);
      sample("R9 cancel", 32767, -32768, -32768, -32768, -32768, 0);
      // R8: reset mid-run clears history
      sample("R8 load", 0, 1000, 0, 0, 0, 0);
      sample("R8 load", 0, 2000, 0, 0, 0, 0);
      do_reset();
      sample("R8 cleared history", 0, 0, 0, 0, ONE, ONE);
      repeat (3) @(negedge clk);
      check("R4 queue drained", exp_q.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule